// File: doc/BRIEF.md
# Memory-Mapped Request Pipeline Stage

This block sits between a memory-mapped master and a slave and adds one register stage to the request path. The request path carries the address, write data, byte enables and the read and write strobes. The read data and read-valid response is not registered: it passes straight from the slave back to the master.

Flow control works like a ready pipeline with no skid buffer. The slave's waitrequest is the inverse of a ready signal that acknowledges the access now on the bus. When the stage register is empty it always takes the next access. Waitrequest goes back to the master only when the register holds an access and the slave is stalling. A pending access leaves the register in the same cycle the slave becomes ready. If the master offers a new access in that cycle, the register loads it with no idle cycle in between. A parameter replaces the register with plain wires. In that mode waitrequest passes back unchanged.

Top module: `mm_pipe_stage`

## Requirements
- R1: While the asynchronous reset is high, and in the first cycle after it, the downstream read and write strobes are low and the upstream waitrequest is low, whatever the downstream waitrequest is.
- R2: In registered mode, an access that the master offers while upstream waitrequest is low appears downstream in the next cycle, with its address, write data, byte enables and strobe unchanged.
- R3: In registered mode, when the register is empty the upstream waitrequest is low, even while downstream waitrequest is high.
- R4: In registered mode, upstream waitrequest is high exactly when downstream waitrequest is high and the register holds an access (read or write strobe registered).
- R5: In registered mode, the downstream read and write strobes are both low in any cycle where downstream waitrequest is high.
- R6: In registered mode, a held access is issued downstream in the first cycle downstream waitrequest is low. If the master offers nothing in that cycle, the downstream strobes are low in the following cycle.
- R7: In registered mode, when the register is full and downstream waitrequest is low, a new access offered by the master in that cycle is accepted: upstream waitrequest is low, and the new access is issued downstream in the next cycle.
- R8: In registered mode, the downstream address, write data and byte enables stay constant while upstream waitrequest is high.
- R9: In both modes, the downstream read data and read-valid reach the master combinationally, in the same cycle.
- R10: In wire mode (REGISTERED = 0), every downstream request signal equals its upstream counterpart in the same cycle, and upstream waitrequest equals downstream waitrequest.
- R11: In registered mode, under any downstream waitrequest pattern, every access the master has had accepted is issued downstream exactly once and in the order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| m_addr | input | AW | Address from the master |
| m_wdata | input | DW | Write data from the master |
| m_be | input | BW | Byte enables from the master |
| m_rd | input | 1 | Read strobe from the master |
| m_wr | input | 1 | Write strobe from the master |
| m_wait | output | 1 | Waitrequest to the master |
| m_rdata | output | DW | Read data to the master |
| m_rvalid | output | 1 | Read-valid to the master |
| s_addr | output | AW | Address to the slave |
| s_wdata | output | DW | Write data to the slave |
| s_be | output | BW | Byte enables to the slave |
| s_rd | output | 1 | Read strobe to the slave |
| s_wr | output | 1 | Write strobe to the slave |
| s_wait | input | 1 | Waitrequest from the slave |
| s_rdata | input | DW | Read data from the slave |
| s_rvalid | input | 1 | Read-valid from the slave |

## Verification
The bench builds two copies side by side with AW = 8 and DW = 16. One has REGISTERED = 1 and the other REGISTERED = 0, and both see the same stimulus. With this pairing, each vector compares the one-cycle-late, waitrequest-gated output of the register against the same-cycle pass-through of the wires. The registered copy then runs a long random waitrequest pattern, which covers full-register stalls, back-to-back reloads and emptying on ready. It also receives a reset in the middle of a stalled access.

// File: rtl/mm_pipe_stage.sv
module mm_pipe_stage #(
  parameter bit REGISTERED = 1'b1,
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int BW         = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [BW-1:0] m_be,
  input  logic          m_rd,
  input  logic          m_wr,
  output logic          m_wait,
  output logic [DW-1:0] m_rdata,
  output logic          m_rvalid,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  output logic [BW-1:0] s_be,
  output logic          s_rd,
  output logic          s_wr,
  input  logic          s_wait,
  input  logic [DW-1:0] s_rdata,
  input  logic          s_rvalid
);

  assign m_rdata  = s_rdata;
  assign m_rvalid = s_rvalid;

  if (REGISTERED) begin : g_reg
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_wdata;
    logic [BW-1:0] q_be;
    logic          q_rd, q_wr;
    logic          full, rdy, take;

    assign full = q_rd | q_wr;
    assign rdy  = ~s_wait;
    assign take = ~full | rdy;

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        q_addr  <= '0;
        q_wdata <= '0;
        q_be    <= '0;
        q_rd    <= 1'b0;
        q_wr    <= 1'b0;
      end else if (take) begin
        q_addr  <= m_addr;
        q_wdata <= m_wdata;
        q_be    <= m_be;
        q_rd    <= m_rd;
        q_wr    <= m_wr;
      end
    end

    assign s_addr  = q_addr;
    assign s_wdata = q_wdata;
    assign s_be    = q_be;
    assign s_rd    = q_rd & rdy;
    assign s_wr    = q_wr & rdy;
    assign m_wait  = s_wait & full;

    AST_NO_ISSUE_IN_STALL: assert property (@(posedge clk) disable iff (rst)
      s_wait |-> !(s_rd || s_wr)); // R5
    AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (rst)
      (!m_wait && (m_rd || m_wr)) |=> (s_addr == $past(m_addr) && s_wdata == $past(m_wdata)
                                       && s_be == $past(m_be))); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      m_wait |=> ($stable(s_addr) && $stable(s_wdata) && $stable(s_be))); // R8
    AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (rst)
      m_wait |=> (m_wait || s_rd || s_wr)); // R6
    AST_WAIT_NEEDS_STALL: assert property (@(posedge clk) disable iff (rst)
      m_wait |-> s_wait); // R4
  end else begin : g_wire
    assign s_addr  = m_addr;
    assign s_wdata = m_wdata;
    assign s_be    = m_be;
    assign s_rd    = m_rd;
    assign s_wr    = m_wr;
    assign m_wait  = s_wait;
  end

endmodule

// File: tb/test_mm_pipe_stage.sv
module test_mm_pipe_stage;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int BW = DW / 8;
  localparam int NV = 11;
  localparam int NACC = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [BW-1:0] m_be = '0;
  logic m_rd = 1'b0, m_wr = 1'b0, s_wait = 1'b0, s_rvalid = 1'b0;
  logic [DW-1:0] s_rdata = '0;

  logic m_wait, m_rvalid, s_rd, s_wr;
  logic [DW-1:0] m_rdata, s_wdata;
  logic [AW-1:0] s_addr;
  logic [BW-1:0] s_be;
  logic w_wait, w_rvalid, w_rd, w_wr;
  logic [DW-1:0] w_rdata, w_wdata;
  logic [AW-1:0] w_addr;
  logic [BW-1:0] w_be;

  mm_pipe_stage #(.REGISTERED(1'b1), .AW(AW), .DW(DW), .BW(BW)) i_mm_pipe_stage (
    .clk, .rst, .m_addr, .m_wdata, .m_be, .m_rd, .m_wr, .m_wait, .m_rdata, .m_rvalid,
    .s_addr, .s_wdata, .s_be, .s_rd, .s_wr, .s_wait, .s_rdata, .s_rvalid);

  mm_pipe_stage #(.REGISTERED(1'b0), .AW(AW), .DW(DW), .BW(BW)) i_mm_pipe_stage_wire (
    .clk, .rst, .m_addr, .m_wdata, .m_be, .m_rd, .m_wr, .m_wait(w_wait),
    .m_rdata(w_rdata), .m_rvalid(w_rvalid), .s_addr(w_addr), .s_wdata(w_wdata),
    .s_be(w_be), .s_rd(w_rd), .s_wr(w_wr), .s_wait, .s_rdata, .s_rvalid);

  // {m_rd, m_wr, m_addr, s_wait, exp m_wait, exp s_rd, exp s_wr, exp s_addr}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11},
    {1'b1, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b0, 1'b0, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h33},
    {1'b0, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55}
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int exp_idx, cur, sent;
    bit busy;
    // R1: during reset
    s_wait = 1'b1;
    repeat (3) @(negedge clk);
    chk(!s_rd && !s_wr, "R1 strobes in reset", {s_rd, s_wr}, 0);
    chk(!m_wait, "R1 wait in reset", m_wait, 0);
    rst = 1'b0;
    #1;
    chk(!s_rd && !s_wr && !m_wait, "R1 after reset", {m_wait, s_rd, s_wr}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 and R10 on the wire copy
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      m_rd = VEC[i][21]; m_wr = VEC[i][20]; m_addr = VEC[i][19:12]; s_wait = VEC[i][11];
      m_wdata = {8'h00, VEC[i][19:12]};
      #1;
      chk(m_wait == VEC[i][10], "R3/R4 m_wait", m_wait, VEC[i][10]);
      chk(s_rd == VEC[i][9] && s_wr == VEC[i][8], "R2/R5/R6/R7 strobes", {s_rd, s_wr}, VEC[i][9:8]);
      chk(s_addr == VEC[i][7:0], "R2 s_addr", s_addr, VEC[i][7:0]);
      chk(w_addr == m_addr && w_rd == m_rd && w_wr == m_wr && w_wdata == m_wdata && w_be == m_be,
          "R10 wire request", {w_rd, w_wr, w_addr}, {m_rd, m_wr, m_addr});
      chk(w_wait == s_wait, "R10 wire wait", w_wait, s_wait);
    end

    // R9: response passthrough in both modes
    @(negedge clk);
    m_rd = 1'b0; m_wr = 1'b0; s_wait = 1'b0; s_rdata = 16'h1234; s_rvalid = 1'b1;
    #1;
    chk(m_rdata == 16'h1234 && m_rvalid, "R9 registered", {m_rvalid, m_rdata}, {1'b1, 16'h1234});
    chk(w_rdata == 16'h1234 && w_rvalid, "R9 wire", {w_rvalid, w_rdata}, {1'b1, 16'h1234});
    s_rvalid = 1'b0;

    // R8: hold fields while stalled
    @(negedge clk);
    m_wr = 1'b1; m_addr = 8'h66; m_wdata = 16'hABCD; m_be = 2'b10; s_wait = 1'b1;
    @(negedge clk);
    m_addr = 8'h77; m_wdata = 16'h5555; m_be = 2'b01;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(m_wait, "R4 stalled full", m_wait, 1);
      chk(s_addr == 8'h66 && s_wdata == 16'hABCD && s_be == 2'b10, "R8 hold",
          {s_addr, s_wdata, s_be}, {8'h66, 16'hABCD, 2'b10});
      @(negedge clk);
    end

    // R1: asynchronous reset with a pending access
    #1 rst = 1'b1;
    #1;
    chk(!m_wait && !s_wr && !s_rd, "R1 mid reset", {m_wait, s_wr}, 0);
    @(negedge clk);
    m_wr = 1'b0;
    rst = 1'b0;

    // R11: random waitrequest, exactly once and in order
    exp_idx = 0; cur = 0; sent = 0; busy = 1'b0;
    for (int c = 0; c < 4000 && exp_idx < NACC; c++) begin
      @(negedge clk);
      s_wait = ($urandom % 100) < 45;
      if (!busy && sent < NACC && ($urandom % 100) < 70) begin
        busy = 1'b1;
        cur = sent;
      end
      m_rd = busy && (cur % 3 == 0);
      m_wr = busy && (cur % 3 != 0);
      m_addr = cur[7:0];
      m_wdata = 16'(cur * 3);
      m_be = 2'b11;
      #1;
      if (s_rd || s_wr) begin
        chk(!s_wait, "R5 issue while stalled", s_wait, 0);
        chk(s_addr == exp_idx[7:0] && s_rd == (exp_idx % 3 == 0), "R11 order",
            s_addr, exp_idx[7:0]);
        if (s_wr) chk(s_wdata == 16'(exp_idx * 3), "R11 wdata", s_wdata, 16'(exp_idx * 3));
        exp_idx++;
      end
      if (busy && !m_wait) begin
        busy = 1'b0;
        sent++;
      end
    end
    @(negedge clk);
    m_rd = 1'b0; m_wr = 1'b0; s_wait = 1'b0;
    #1;
    if (s_rd || s_wr) exp_idx++;
    chk(exp_idx == NACC, "R11 delivered count", exp_idx, NACC);
    @(negedge clk);
    #1;
    chk(!s_rd && !s_wr, "R6 empties", {s_rd, s_wr}, 0);
    finish_run();
  end
endmodule